// File: doc/BRIEF.md
# Serial Character Receiver with Line-Error Tagging

This block is the receive half of an asynchronous serial port. It watches a single RX line, using a tick that arrives 16 times per bit period. From that line it builds characters: a low start bit, then 5 to 8 data bits least significant bit first, then an optional parity bit, then a high stop bit. Each finished character comes out on a one-cycle strobe. The data and three error tags travel with it: wrong parity, a low stop bit (framing) and a line held low for a whole character (break).

The line first passes through a synchronizer. Every bit is then sampled once, at its middle. The receiver recovers from faults in two ways. A character whose stop bit reads low is reported with a framing error, and that low stop bit is taken at once as the start bit of the next character. A break is reported as a character of all zeros with both the break and framing tags set. After a break the receiver does not look for a new start bit until the line has gone high again. Word length and parity are set on static inputs, which are changed only while the line is idle. Storage for received characters, status registers and any bus access are the job of the surrounding logic.

Top module: `rx_char_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, `chr_valid` is 0 and `chr_data`, `tag_parity`, `tag_frame` and `tag_break` are all 0.
- R2: After a falling edge on the synchronized line, the receiver counts 8 ticks and samples the line again. If the line is high at that point, the start is dropped as a glitch and no character is produced.
- R3: `cfg_len` selects the number of data bits, 5 + `cfg_len`, so the codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. The first data bit received lands in `chr_data[0]`, and the unused upper bits of `chr_data` read 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `tag_parity` is set when the count of ones in the data bits plus the parity bit is odd while `cfg_par_odd` is 0, or even while `cfg_par_odd` is 1. When `cfg_par_en` is 0, `tag_parity` is 0.
- R5: `tag_frame` is 1 exactly when the sampled stop bit is 0.
- R6: After a framing error that is not a break, the low stop bit counts as the start bit of the next character. The first data bit of that next character is sampled 16 ticks after the stop-bit sample.
- R7: When the start bit, every data bit, the parity bit (if enabled) and the stop bit are all sampled low, the character is delivered with `chr_data` = 0, `tag_break` = 1 and `tag_frame` = 1.
- R8: After a break, no new character is started until the line has been sampled high on a tick. Holding the line low longer produces no further strobe.
- R9: `chr_valid` is high for exactly one cycle per character. That cycle is the one right after the clock edge at which the stop-bit tick is sampled. `chr_data` and the tags change only together with `chr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input; idle level is high |
| os_tick | input | 1 | One-cycle enable, 16 per bit period |
| cfg_len | input | 2 | Data bit count minus 5 |
| cfg_par_en | input | 1 | 1 means a parity bit follows the data |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| chr_valid | output | 1 | One-cycle strobe: a character has been assembled |
| chr_data | output | DATA_W | Received character, right-aligned |
| tag_parity | output | 1 | Parity mismatch on this character |
| tag_frame | output | 1 | Stop bit was sampled low |
| tag_break | output | 1 | The whole character time was low |

## Verification
The receiver is driven with clean frames in all four word lengths, with parity off, even and odd, and with correct and inverted parity bits. These runs show whether the bit count, the bit order and the parity sense are right. A short low pulse tells a real mid-bit start check apart from a plain edge trigger. A frame whose stop bit is low, followed directly by the data bits of a second frame with no separate start bit, shows whether the low stop bit is reused as the next start bit. A long low stretch, and then a longer one, separates a correct break report from one that fires again while the line is still low. A behavioural reference model in the bench predicts the strobe and its fields on every clock cycle.

// File: rtl/rx_char_pkg.sv
package rx_char_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_char_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxs,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              berr_o
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e         st_q;
  logic [CW-1:0]     tcnt_q;
  logic [IW-1:0]     bidx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              zero_q;
  logic              par_q;
  logic [IW-1:0]     last_idx;

  assign last_idx = IW'(4) + IW'(cfg_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      zero_q  <= 1'b0;
      par_q   <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      berr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick) begin
        unique case (st_q)
          ST_IDLE: begin
            if (!rxs) begin
              st_q   <= ST_START;
              tcnt_q <= '0;
            end
          end
          ST_START: begin
            if (tcnt_q == MID) begin
              if (rxs) begin
                st_q <= ST_IDLE;
              end else begin
                st_q    <= ST_DATA;
                tcnt_q  <= '0;
                bidx_q  <= '0;
                shreg_q <= '0;
                zero_q  <= 1'b1;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (tcnt_q == LAST) begin
              tcnt_q          <= '0;
              shreg_q[bidx_q] <= rxs;
              if (rxs) zero_q <= 1'b0;
              if (bidx_q == last_idx) st_q <= cfg_par_en ? ST_PAR : ST_STOP;
              else                    bidx_q <= bidx_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (tcnt_q == LAST) begin
              tcnt_q <= '0;
              par_q  <= rxs;
              if (rxs) zero_q <= 1'b0;
              st_q   <= ST_STOP;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (tcnt_q == LAST) begin
              tcnt_q  <= '0;
              valid_o <= 1'b1;
              data_o  <= shreg_q;
              ferr_o  <= !rxs;
              berr_o  <= zero_q && !rxs;
              perr_o  <= cfg_par_en && ((^shreg_q) ^ par_q ^ cfg_par_odd);
              if (zero_q && !rxs) begin
                st_q <= ST_BRK;
              end else if (!rxs) begin
                st_q    <= ST_DATA;
                bidx_q  <= '0;
                shreg_q <= '0;
                zero_q  <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_BRK: begin
            if (rxs) st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: a start that reads high at its midpoint returns to idle
  p_glitch_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_START && tick && tcnt_q == MID && rxs) |=> (st_q == ST_IDLE && !valid_o));

  // R8: the break hold is left only after a high sample on a tick
  p_break_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BRK && !(tick && rxs)) |=> (st_q == ST_BRK));
endmodule

// File: rtl/rx_char_engine.sv
module rx_char_engine #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              chr_valid,
  output logic [DATA_W-1:0] chr_data,
  output logic              tag_parity,
  output logic              tag_frame,
  output logic              tag_break
);
  logic rx_sync;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (rx_line),
    .d_out (rx_sync)
  );

  rx_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick        (os_tick),
    .rxs         (rx_sync),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .valid_o     (chr_valid),
    .data_o      (chr_data),
    .perr_o      (tag_parity),
    .ferr_o      (tag_frame),
    .berr_o      (tag_break)
  );

  // R9: the strobe never lasts two cycles
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
    chr_valid |=> !chr_valid);

  // R9: data and tags move only together with the strobe
  p_quiet_fields_r9: assert property (@(posedge clk) disable iff (rst)
    !chr_valid |-> ($stable(chr_data) && $stable(tag_parity) && $stable(tag_frame) && $stable(tag_break)));

  // R7: a break always carries zero data and a framing tag
  p_break_frame_r7: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && tag_break) |-> (tag_frame && chr_data == '0));
endmodule

// File: tb/rx_char_engine_test.sv
module rx_char_engine_test;
  localparam int BITC = 64; // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       chr_valid;
  logic [7:0] chr_data;
  logic       tag_parity, tag_frame, tag_break;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  rx_char_engine uut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .chr_valid(chr_valid), .chr_data(chr_data),
    .tag_parity(tag_parity), .tag_frame(tag_frame), .tag_break(tag_break)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // tick generator: one tick every 4 clocks
  int tdiv = 0;
  always @(negedge clk) begin
    cyc++;
    tdiv = (tdiv + 1) % 4;
    os_tick <= (tdiv == 0) && !rst;
  end

  // behavioural reference model working on tick counts since the start edge
  int  mst, k, nb, n;
  bit  m1, m2, line;
  bit  [7:0] md;
  bit  mp, mz;
  bit  ev;
  bit  [7:0] ed;
  bit  ep, ef, eb;
  always @(posedge clk) begin
    if (rst) begin
      mst = 0; m1 = 1; m2 = 1; k = 0;
      ev <= 0; ed <= 0; ep <= 0; ef <= 0; eb <= 0;
    end else begin
      line = m2; m2 = m1; m1 = rx_line;
      ev <= 0;
      if (os_tick) begin
        case (mst)
          0: if (!line) begin mst = 1; k = 0; md = 0; mz = 1; end
          1: begin
            k++;
            nb = 5 + int'(cfg_len);
            if (k == 8) begin
              if (line) mst = 0;
            end else if (k > 8 && (k - 8) % 16 == 0) begin
              n = (k - 8) / 16;
              if (n <= nb) begin
                md[n-1] = line; if (line) mz = 0;
              end else if (cfg_par_en && n == nb + 1) begin
                mp = line; if (line) mz = 0;
              end else begin
                ev <= 1; ed <= md; ef <= !line; eb <= mz && !line;
                ep <= cfg_par_en && (((($countones(md)) + int'(mp)) % 2) != int'(cfg_par_odd));
                if (mz && !line) mst = 2;
                else if (!line) begin k = 8; md = 0; mz = 1; end
                else mst = 0;
              end
            end
          end
          default: if (line) mst = 0;
        endcase
      end
    end
  end

  // per-cycle comparison and capture of delivered characters
  bit [10:0] cap[$];
  always @(negedge clk) begin
    if (!rst) begin
      chk(chr_valid == ev, "R9 strobe", chr_valid, ev);
      chk(chr_data == ed, "R3 data", chr_data, ed);
      chk(tag_parity == ep, "R4 parity tag", tag_parity, ep);
      chk(tag_frame == ef, "R5 frame tag", tag_frame, ef);
      chk(tag_break == eb, "R7 break tag", tag_break, eb);
      if (chr_valid) cap.push_back({tag_break, tag_frame, tag_parity, chr_data});
    end
  end

  task automatic bit_out(input bit v, input int nbits);
    rx_line = v;
    repeat (nbits * BITC) @(negedge clk);
  endtask

  task automatic frame(input bit [7:0] d, input int nbd, input bit pe, input bit po,
                       input bit flip, input bit stp, input bit with_start);
    bit p;
    if (with_start) bit_out(1'b0, 1);
    p = po ^ flip;
    for (int i = 0; i < nbd; i++) begin
      bit_out(d[i], 1);
      p ^= d[i];
    end
    if (pe) bit_out(p, 1);
    bit_out(stp, 1);
  endtask

  task automatic setcfg(input int nbd, input bit pe, input bit po);
    cfg_len = 2'(nbd - 5); cfg_par_en = pe; cfg_par_odd = po;
    bit_out(1'b1, 2);
  endtask

  task automatic expect_one(input string req, input bit [10:0] want);
    chk(cap.size() == 1, req, cap.size(), 1);
    if (cap.size() > 0) chk(cap[0] == want, req, cap[0], want);
    cap.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values, held through reset and the first cycle after
    chk({chr_valid, chr_data, tag_parity, tag_frame, tag_break} == 0, "R1 reset", chr_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({chr_valid, chr_data, tag_parity, tag_frame, tag_break} == 0, "R1 after reset", chr_data, 0);
    bit_out(1'b1, 2);

    // R3: 8 bits, no parity
    setcfg(8, 0, 0); frame(8'hA5, 8, 0, 0, 0, 1, 1); bit_out(1'b1, 2);
    expect_one("R3 8N1 0xA5", {3'b000, 8'hA5});
    frame(8'h3C, 8, 0, 0, 0, 1, 1); bit_out(1'b1, 2);
    expect_one("R3 8N1 0x3C", {3'b000, 8'h3C});

    // R3/R4: 5 bits even parity, correct then wrong parity
    setcfg(5, 1, 0); frame(8'h15, 5, 1, 0, 0, 1, 1); bit_out(1'b1, 2);
    expect_one("R4 5E1 good", {3'b000, 8'h15});
    frame(8'h15, 5, 1, 0, 1, 1, 1); bit_out(1'b1, 2);
    expect_one("R4 5E1 bad", {3'b001, 8'h15});

    // R4: 7 bits odd parity
    setcfg(7, 1, 1); frame(8'h6B, 7, 1, 1, 0, 1, 1); bit_out(1'b1, 2);
    expect_one("R4 7O1 good", {3'b000, 8'h6B});
    frame(8'h6B, 7, 1, 1, 1, 1, 1); bit_out(1'b1, 2);
    expect_one("R4 7O1 bad", {3'b001, 8'h6B});

    // R3: 6 bits, upper bits zero
    setcfg(6, 0, 0); frame(8'hFF, 6, 0, 0, 0, 1, 1); bit_out(1'b1, 2);
    expect_one("R3 6N1 upper zero", {3'b000, 8'h3F});

    // R2: a 3-tick low pulse is rejected
    setcfg(8, 0, 0);
    rx_line = 1'b0; repeat (12) @(negedge clk);
    bit_out(1'b1, 3);
    chk(cap.size() == 0, "R2 glitch rejected", cap.size(), 0);
    cap.delete();

    // R5/R6: low stop bit reused as the next start bit
    frame(8'h5A, 8, 0, 0, 0, 0, 1);
    frame(8'hC3, 8, 0, 0, 0, 1, 0);
    bit_out(1'b1, 2);
    chk(cap.size() == 2, "R6 resync count", cap.size(), 2);
    if (cap.size() == 2) begin
      chk(cap[0] == {3'b010, 8'h5A}, "R5 frame tagged", cap[0], {3'b010, 8'h5A});
      chk(cap[1] == {3'b000, 8'hC3}, "R6 resync char", cap[1], {3'b000, 8'hC3});
    end
    cap.delete();

    // R7/R8: break, then a longer break, one strobe each
    bit_out(1'b0, 12); bit_out(1'b1, 2);
    expect_one("R7 break 8N1", {3'b110, 8'h00});
    bit_out(1'b0, 30); bit_out(1'b1, 2);
    expect_one("R8 long break single strobe", {3'b110, 8'h00});

    // R7: break with odd parity enabled also flags parity
    setcfg(5, 1, 1);
    bit_out(1'b0, 9); bit_out(1'b1, 2);
    expect_one("R7 break 5O1", {3'b111, 8'h00});

    // R8: after a break, a new frame is received once the line is high
    frame(8'h0A, 5, 1, 1, 0, 1, 1); bit_out(1'b1, 2);
    expect_one("R8 recovery after break", {3'b000, 8'h0A});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule